// File: doc/BRIEF.md
# Power-Up and Mute Sequencer

This block steers the lifecycle of a two-channel programmable gain stage. It takes a supply-good flag from an external comparator, an active-low mute pin, a one-millisecond tick and a calibration-done handshake. From these it produces four controls: a hardware-mute output, a reset for the control registers, a single-cycle pulse that starts offset calibration, and a pulse that forces both channel gain codes to zero. It also gates the serial write strobe, so the host can load gain codes only during normal operation.

After the supply becomes good, the control registers are held in reset for a timed window of `RST_MS` ticks. Calibration then starts by itself. When calibration reports done, both gain codes are cleared, which leaves the channels in software mute until the host loads new values. If the supply drops at any point, the block falls into a brownout state with the output muted. When the supply recovers, the whole sequence runs again from the timed reset. Both external inputs pass through synchronizers. The mute pin is also debounced over `DEB_MS` ticks. Once debounced, an assertion of the mute pin mutes the outputs and starts a fresh calibration, and it leaves the gain codes alone.

Top module: `pwr_mute_seq`

## Requirements
- R1: While `rst_n` is low, and whenever the state is not RUN: `hw_mute` is 1 and `wr_accept` is 0. During `rst_n` low, `regs_rst`=1, `cal_start`=0, `gain_zero`=0 and `state_oh`=RESET.
- R2: In RESET with the supply good, the block counts `ms_tick` pulses. The tick that brings the count to `RST_MS` moves the state to CALIBRATE. In the cycle after that tick, `cal_start` is high for exactly one cycle and `regs_rst` is 0. After `RST_MS`-1 ticks, the state is still RESET.
- R3: In CALIBRATE, `hw_mute` stays 1 and ticks have no effect. The block stays in CALIBRATE until `cal_done` is sampled high.
- R4: The clock edge that samples `cal_done` high in CALIBRATE moves the state to INIT_MUTE. In INIT_MUTE, `gain_zero` is 1 for one cycle, and the next state is RUN. A `cal_done` outside CALIBRATE produces no `gain_zero`.
- R5: A low supply-good flag, seen after the synchronizer, sends any state to BROWNOUT. In BROWNOUT, `hw_mute`=1 and `regs_rst`=1. A good supply moves BROWNOUT to RESET with the tick count cleared, so the full `RST_MS` window is counted again.
- R6: In RUN, `mute_n` held low for `DEB_MS` ticks sets `hw_mute`, and the next cycle carries one `cal_start` pulse with no `gain_zero`. A low level shorter than `DEB_MS` ticks changes nothing. Release takes effect after `DEB_MS` high ticks, with no pulse.
- R7: `wr_accept` equals `wr_req` in RUN and is 0 in every other state.
- R8: `state_oh` is one-hot with bit 0 RESET, bit 1 CALIBRATE, bit 2 INIT_MUTE, bit 3 RUN and bit 4 BROWNOUT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply above threshold (asynchronous) |
| mute_n | input | 1 | Hardware mute pin, active low (asynchronous) |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| cal_done | input | 1 | Calibration engine finished |
| wr_req | input | 1 | Serial gain-write strobe from the port |
| hw_mute | output | 1 | Disconnect outputs and terminate to ground |
| regs_rst | output | 1 | Clear all control registers |
| cal_start | output | 1 | One-cycle calibration start pulse |
| gain_zero | output | 1 | Force both gain codes to 00h |
| wr_accept | output | 1 | Gated write strobe |
| state_oh | output | 5 | One-hot sequencer state |

## Verification
Every asynchronous input change reaches the state register on the third clock edge. For that reason, the bench waits three cycles after moving `supply_ok` or `mute_n` before it issues any tick, and no tick can land inside the synchronizer latency. State and mute outputs settle in the cycle after the tick that ends a window. `cal_start` follows one cycle later on the mute path, and `gain_zero` shows in the cycle after `cal_done` is sampled. Single-cycle pulses are counted by a negative-edge monitor, not sampled once. Every window is probed one tick before its end and again at its end, so off-by-one counts show up.

// File: rtl/pms_pkg.sv
package pms_pkg;
  localparam int N_STATES = 5;
  localparam int IDX_RESET = 0;
  localparam int IDX_CAL   = 1;
  localparam int IDX_INIT  = 2;
  localparam int IDX_RUN   = 3;
  localparam int IDX_BROWN = 4;

  typedef enum logic [N_STATES-1:0] {
    S_RESET = 5'b00001,
    S_CAL   = 5'b00010,
    S_INIT  = 5'b00100,
    S_RUN   = 5'b01000,
    S_BROWN = 5'b10000
  } pms_state_e;
endpackage

// File: rtl/pms_sync.sv
module pms_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= {STAGES{RST_VAL}};
    else        sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/pms_debounce.sv
module pms_debounce #(
  parameter int DEB_MS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic tick,
  output logic deb
);
  localparam int CW = (DEB_MS < 2) ? 1 : $clog2(DEB_MS + 1);
  localparam logic [CW-1:0] LAST = CW'(DEB_MS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          deb_q, deb_d;

  always_comb begin
    cnt_d = cnt_q;
    deb_d = deb_q;
    if (raw == deb_q) begin
      cnt_d = '0;
    end else if (tick) begin
      if (cnt_q == LAST) begin
        cnt_d = '0;
        deb_d = raw;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      deb_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      deb_q <= deb_d;
    end
  end

  assign deb = deb_q;
endmodule

// File: rtl/pms_fsm.sv
module pms_fsm
  import pms_pkg::*;
#(
  parameter int RST_MS = 100
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sup_good,
  input  logic                mute_act,
  input  logic                tick,
  input  logic                cal_done,
  input  logic                wr_req,
  output logic                hw_mute,
  output logic                regs_rst,
  output logic                cal_start,
  output logic                gain_zero,
  output logic                wr_accept,
  output logic [N_STATES-1:0] state_oh
);
  localparam int CW = $clog2(RST_MS + 1);
  localparam logic [CW-1:0] LAST = CW'(RST_MS - 1);

  pms_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          mute_q;
  logic          pulse_q, pulse_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_RESET: if (!sup_good) state_d = S_BROWN;
               else if (tick && cnt_q == LAST) state_d = S_CAL;
      S_CAL:   if (!sup_good) state_d = S_BROWN;
               else if (cal_done) state_d = S_INIT;
      S_INIT:  if (!sup_good) state_d = S_BROWN;
               else state_d = S_RUN;
      S_RUN:   if (!sup_good) state_d = S_BROWN;
      S_BROWN: if (sup_good) state_d = S_RESET;
      default: state_d = S_BROWN;
    endcase
  end

  always_comb begin
    cnt_d = '0;
    if (state_q == S_RESET && sup_good)
      cnt_d = tick ? cnt_q + CW'(1) : cnt_q;
  end

  always_comb begin
    pulse_d = 1'b0;
    if (state_q == S_RESET && state_d == S_CAL) pulse_d = 1'b1;
    if (state_q == S_RUN && sup_good && mute_act && !mute_q) pulse_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_RESET;
      cnt_q   <= '0;
      mute_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      mute_q  <= mute_act;
      pulse_q <= pulse_d;
    end
  end

  assign state_oh  = state_q;
  assign hw_mute   = !state_q[IDX_RUN] || mute_act;
  assign regs_rst  = state_q[IDX_RESET] || state_q[IDX_BROWN];
  assign gain_zero = state_q[IDX_INIT];
  assign wr_accept = state_q[IDX_RUN] && wr_req;
  assign cal_start = pulse_q;
endmodule

// File: rtl/pwr_mute_seq.sv
module pwr_mute_seq #(
  parameter int RST_MS      = 100,
  parameter int DEB_MS      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       mute_n,
  input  logic       ms_tick,
  input  logic       cal_done,
  input  logic       wr_req,
  output logic       hw_mute,
  output logic       regs_rst,
  output logic       cal_start,
  output logic       gain_zero,
  output logic       wr_accept,
  output logic [4:0] state_oh
);
  logic sup_s, mute_n_s, mute_deb;

  pms_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sup (
    .clk(clk), .rst_n(rst_n), .d(supply_ok), .q(sup_s));

  pms_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_mute (
    .clk(clk), .rst_n(rst_n), .d(mute_n), .q(mute_n_s));

  pms_debounce #(.DEB_MS(DEB_MS)) u_deb (
    .clk(clk), .rst_n(rst_n), .raw(!mute_n_s), .tick(ms_tick), .deb(mute_deb));

  pms_fsm #(.RST_MS(RST_MS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sup_good(sup_s), .mute_act(mute_deb),
    .tick(ms_tick), .cal_done(cal_done), .wr_req(wr_req),
    .hw_mute(hw_mute), .regs_rst(regs_rst), .cal_start(cal_start),
    .gain_zero(gain_zero), .wr_accept(wr_accept), .state_oh(state_oh));
endmodule

// File: rtl/pms_checker.sv
module pms_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_req,
  input logic       hw_mute,
  input logic       regs_rst,
  input logic       cal_start,
  input logic       gain_zero,
  input logic       wr_accept,
  input logic [4:0] state_oh
);
  AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(state_oh) == 1); // R8
  AST_MUTE_OUTSIDE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    !state_oh[3] |-> hw_mute); // R1
  AST_CAL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |=> !cal_start); // R2
  AST_CAL_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_oh[1]) |-> cal_start); // R2
  AST_CAL_HOLDS_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
    state_oh[1] |-> hw_mute && !regs_rst); // R3
  AST_ZERO_THEN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    gain_zero |=> (state_oh[3] || state_oh[4]) && !gain_zero); // R4
  AST_BROWN_MUTED: assert property (@(posedge clk) disable iff (!rst_n)
    state_oh[4] |-> hw_mute && regs_rst); // R5
  AST_WRITE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |-> state_oh[3] && wr_req); // R7
endmodule

bind pwr_mute_seq pms_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .hw_mute(hw_mute),
  .regs_rst(regs_rst), .cal_start(cal_start), .gain_zero(gain_zero),
  .wr_accept(wr_accept), .state_oh(state_oh));

// File: tb/pwr_mute_seq_test.sv
`timescale 1ns/1ps
module pwr_mute_seq_test;
  localparam int RST_MS = 6;
  localparam int DEB_MS = 3;
  localparam logic [4:0] ST_RESET = 5'b00001, ST_CAL = 5'b00010,
                         ST_INIT = 5'b00100, ST_RUN = 5'b01000, ST_BROWN = 5'b10000;

  logic clk = 1'b0;
  logic rst_n, supply_ok, mute_n, ms_tick, cal_done, wr_req;
  logic hw_mute, regs_rst, cal_start, gain_zero, wr_accept;
  logic [4:0] state_oh;
  int total = 0, bad = 0;
  int cal_pulses = 0, gz_pulses = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwr_mute_seq #(.RST_MS(RST_MS), .DEB_MS(DEB_MS)) uut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .mute_n(mute_n),
    .ms_tick(ms_tick), .cal_done(cal_done), .wr_req(wr_req),
    .hw_mute(hw_mute), .regs_rst(regs_rst), .cal_start(cal_start),
    .gain_zero(gain_zero), .wr_accept(wr_accept), .state_oh(state_oh));

  always @(negedge clk) begin
    if (rst_n && cal_start) cal_pulses++;
    if (rst_n && gain_zero) gz_pulses++;
  end

  task automatic check(input int act, input int exp, input string req);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk) ms_tick = 1'b1;
    @(negedge clk) ms_tick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // calibration model: one-cycle done pulse after a short latency
  task automatic cal_model();
    repeat (4) @(negedge clk);
    cal_done = 1'b1;
    @(negedge clk) cal_done = 1'b0;
  endtask

  task automatic power_up_to_cal(input string req);
    int c0;
    c0 = cal_pulses;
    supply_ok = 1'b1;
    settle();
    check(int'(state_oh), int'(ST_RESET), {req, " reset window entered"});
    for (int i = 1; i < RST_MS; i++) tick();
    check(int'(state_oh), int'(ST_RESET), {req, " still in reset one tick early"});
    check(cal_pulses - c0, 0, {req, " no early cal_start"});
    tick();
    check(int'(state_oh), int'(ST_CAL), {req, " calibrate after window"});
    check(cal_pulses - c0, 1, {req, " one cal_start"});
    check(int'(regs_rst), 0, {req, " regs_rst released"});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int c0, g0;
    rst_n = 1'b0; supply_ok = 1'b0; mute_n = 1'b1; ms_tick = 1'b0;
    cal_done = 1'b0; wr_req = 1'b1;
    settle();
    // R1 reset state
    check(int'(state_oh), int'(ST_RESET), "R1 state in reset");
    check(int'(hw_mute), 1, "R1 hw_mute in reset");
    check(int'(regs_rst), 1, "R1 regs_rst in reset");
    check(int'(cal_start), 0, "R1 cal_start in reset");
    check(int'(gain_zero), 0, "R1 gain_zero in reset");
    check(int'(wr_accept), 0, "R1 wr_accept in reset");
    @(negedge clk) rst_n = 1'b1;
    settle();
    check(int'(state_oh), int'(ST_BROWN), "R5 low supply gives brownout");
    check(int'(regs_rst), 1, "R5 regs_rst in brownout");

    // R2 first power-up
    power_up_to_cal("R2");
    // R3 ticks ignored in calibrate
    for (int i = 0; i < RST_MS + 2; i++) tick();
    check(int'(state_oh), int'(ST_CAL), "R3 ticks ignored in calibrate");
    check(int'(hw_mute), 1, "R3 muted in calibrate");
    check(int'(wr_accept), 0, "R7 write blocked in calibrate");
    // R4 cal_done -> INIT -> RUN
    @(negedge clk) cal_done = 1'b1;
    @(negedge clk) cal_done = 1'b0;
    check(int'(state_oh), int'(ST_INIT), "R4 init after cal_done");
    check(int'(gain_zero), 1, "R4 gain_zero in init");
    @(negedge clk);
    check(int'(state_oh), int'(ST_RUN), "R4 run after init");
    check(int'(gain_zero), 0, "R4 gain_zero one cycle");
    check(int'(hw_mute), 0, "R6 unmuted in run");
    check(int'(wr_accept), 1, "R7 write accepted in run");
    wr_req = 1'b0;
    @(negedge clk);
    check(int'(wr_accept), 0, "R7 accept follows req");
    wr_req = 1'b1;

    // R6 glitch sweep
    for (int g = 1; g < DEB_MS; g++) begin
      c0 = cal_pulses;
      mute_n = 1'b0; settle();
      for (int k = 0; k < g; k++) tick();
      check(int'(hw_mute), 0, "R6 short low not yet muted");
      mute_n = 1'b1; settle();
      for (int k = 0; k < DEB_MS + 1; k++) tick();
      check(int'(hw_mute), 0, "R6 glitch ignored");
      check(cal_pulses - c0, 0, "R6 glitch no cal_start");
    end

    // R6 real mute
    c0 = cal_pulses; g0 = gz_pulses;
    mute_n = 1'b0; settle();
    for (int k = 1; k < DEB_MS; k++) tick();
    check(int'(hw_mute), 0, "R6 mute one tick early");
    tick();
    check(int'(hw_mute), 1, "R6 mute after debounce");
    check(cal_pulses - c0, 1, "R6 mute starts calibration");
    check(int'(state_oh), int'(ST_RUN), "R6 stays in run");
    cal_model();
    @(negedge clk);
    check(gz_pulses - g0, 0, "R4 cal_done in run gives no gain_zero");
    mute_n = 1'b1; settle();
    for (int k = 1; k < DEB_MS; k++) tick();
    check(int'(hw_mute), 1, "R6 release one tick early");
    tick();
    check(int'(hw_mute), 0, "R6 release after debounce");
    check(cal_pulses - c0, 1, "R6 release no cal_start");

    // R5 brownout from run and restart mid-window
    supply_ok = 1'b0; settle();
    check(int'(state_oh), int'(ST_BROWN), "R5 brownout from run");
    check(int'(hw_mute), 1, "R5 muted in brownout");
    check(int'(wr_accept), 0, "R7 write blocked in brownout");
    supply_ok = 1'b1; settle();
    for (int k = 0; k < RST_MS - 2; k++) tick();
    supply_ok = 1'b0; settle();
    check(int'(state_oh), int'(ST_BROWN), "R5 drop inside reset window");
    power_up_to_cal("R5 full window recounted");

    // R5 drop during calibrate; stray cal_done in brownout
    g0 = gz_pulses;
    supply_ok = 1'b0; settle();
    check(int'(state_oh), int'(ST_BROWN), "R5 drop in calibrate");
    cal_model();
    @(negedge clk);
    check(gz_pulses - g0, 0, "R4 cal_done in brownout ignored");
    power_up_to_cal("R2 rerun");
    cal_model();
    @(negedge clk);
    check(int'(state_oh), int'(ST_RUN), "R8 back in run");
    check(gz_pulses - g0, 1, "R4 one gain_zero");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule